// File: doc/BRIEF.md
# PHY Status-Change Interrupt Controller

This block sits beside one transceiver of a multi-port PHY. It watches three status levels: link up, speed and full duplex. A change of any of them, in either direction, can set a sticky event bit that software later reads. The same event can also raise an interrupt request. Several ports can share one interrupt line, because the interrupt pin is driven open-drain and the pins of several ports can be tied together.

Software sets up the block through one 16-bit control/status register. Three controls act at different points:
- A per-source latch-block bit stops a source from recording events at all.
- An interrupt-mask bit and a master-mask bit leave recording alone and only silence the request.
- A global enable turns the whole feature on.

While the enable is set, the transmit LED pin carries the interrupt and the receive LED pin carries the activity signal. While it is clear, both pins carry the LED drive. Reading the register clears the recorded events.

Top module: `phyirq_ctrl`

## Requirements
- R1: After reset, `rd_data_o` is 0 and `irq_o` is 0. `pin_tx_oe_o` is 1, `pin_tx_n_o` follows `led_tx_n_i` and `pin_rx_n_o` follows `led_rx_n_i`.
- R2: Sources map to `stat_i` as follows: bit 0 is link, bit 1 is speed and bit 2 is duplex. A change of source i sets status bit i+1 of `rd_data_o`, in either direction, when the enable is set and the source is not latch-blocked. The bit is set at the first rising clock edge at which the change is seen against the previously sampled level, and it stays set until cleared.
- R3: Bit 0 of `rd_data_o` is 1 exactly when any of status bits 3..1 is 1.
- R4: While the enable (register bit 15) is 0, no status bit becomes set and `irq_o` is 0.
- R5: While the latch-block bit of source i (register bit 4+i) is 1, changes of that source set no status bit. The other sources are unaffected.
- R6: `irq_o` is 1 exactly when all of the following hold: the enable is 1, the interrupt mask (bit 11) is 0, the master mask (bit 12) is 0, and some status bit is set. With the interrupt mask at 1, status bits still latch.
- R7: With the master mask (bit 12) at 1, `irq_o` is 0 whatever the other mask bits are.
- R8: A clock edge with `rd_en_i` high clears all status bits. A change detected at that same edge still sets its own bit.
- R9: A clock edge with `wr_en_i` high loads bits 15, 12, 11 and 6..4 from `wr_data_i`. Written values of bits 3..0 and of all other bits are ignored. Unused bits read 0.
- R10: While the enable is 1, the transmit pin is an open-drain interrupt pin: `pin_tx_n_o` is 0 and `pin_tx_oe_o` equals `irq_o`. `pin_rx_n_o` follows `act_n_i`. While the enable is 0, the pins behave as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| stat_i | input | 3 | Monitored levels: link, speed, duplex |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| rd_en_i | input | 1 | Register read strobe (clears status) |
| rd_data_o | output | 16 | Register contents |
| irq_o | output | 1 | Interrupt request, active high internally |
| led_tx_n_i | input | 1 | Transmit LED drive, active low |
| led_rx_n_i | input | 1 | Receive LED drive, active low |
| act_n_i | input | 1 | Activity drive, active low |
| pin_tx_n_o | output | 1 | Transmit LED / interrupt pin value |
| pin_tx_oe_o | output | 1 | Transmit pin output enable |
| pin_rx_n_o | output | 1 | Receive LED / activity pin value |

## Verification
The directed cases cover four situations:
- rising and falling transitions on each source, which separate a true edge detector from a level or one-direction detector;
- reads that coincide with a fresh change, which separate a clear-then-set order from a plain clear;
- the interrupt-mask, master-mask and latch-block settings applied one at a time, which show which of them stops recording and which only silences the request;
- an all-ones write, which exposes decoding of the unused or read-only bits.

A seeded random phase then toggles the sources, strobes and control values freely. Every cycle of it is compared with a bench model of the register, the request and the pin muxing.

// File: rtl/phyirq_pkg.sv
package phyirq_pkg;
    parameter int unsigned SRC_N     = 3;
    parameter int unsigned REG_W     = 16;
    localparam int unsigned EN_BIT     = 15;
    localparam int unsigned MASTER_BIT = 12;
    localparam int unsigned IMASK_BIT  = 11;
    localparam int unsigned BLK_LSB    = 4;
    localparam int unsigned STS_LSB    = 1;
    localparam int unsigned ANY_BIT    = 0;

    typedef struct packed {
        logic             en;
        logic             master;
        logic             imask;
        logic [SRC_N-1:0] blk;
    } ctrl_t;
endpackage

// File: rtl/sc_edge_detect.sv
module sc_edge_detect #(
    parameter int unsigned N = 3
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] chg_o
);
    typedef struct packed {
        logic [N-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_i;
        chg_o     = sig_i ^ st_q.prev;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end
endmodule

// File: rtl/sc_event_latch.sv
module sc_event_latch #(
    parameter int unsigned N = 3
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [N-1:0] chg_i,
    input  logic         en_i,
    input  logic [N-1:0] blk_i,
    input  logic         clr_i,
    output logic [N-1:0] lat_o
);
    typedef struct packed {
        logic [N-1:0] lat;
    } latch_state_t;

    latch_state_t st_d, st_q;
    logic [N-1:0] set_w;

    always_comb begin
        st_d  = st_q;
        set_w = chg_i & ~blk_i & {N{en_i}};
        if (clr_i) st_d.lat = '0;
        st_d.lat = st_d.lat | set_w;
        lat_o    = st_q.lat;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end
endmodule

// File: rtl/sc_pin_mux.sv
module sc_pin_mux (
    input  logic irq_mode_i,
    input  logic irq_i,
    input  logic led_tx_n_i,
    input  logic led_rx_n_i,
    input  logic act_n_i,
    output logic pin_tx_n_o,
    output logic pin_tx_oe_o,
    output logic pin_rx_n_o
);
    always_comb begin
        if (irq_mode_i) begin
            pin_tx_n_o  = 1'b0;
            pin_tx_oe_o = irq_i;
            pin_rx_n_o  = act_n_i;
        end else begin
            pin_tx_n_o  = led_tx_n_i;
            pin_tx_oe_o = 1'b1;
            pin_rx_n_o  = led_rx_n_i;
        end
    end
endmodule

// File: rtl/phyirq_ctrl.sv
module phyirq_ctrl
    import phyirq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [SRC_N-1:0] stat_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             rd_en_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             irq_o,
    input  logic             led_tx_n_i,
    input  logic             led_rx_n_i,
    input  logic             act_n_i,
    output logic             pin_tx_n_o,
    output logic             pin_tx_oe_o,
    output logic             pin_rx_n_o
);
    typedef struct packed {
        ctrl_t ctrl;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic [SRC_N-1:0] chg_w;
    logic [SRC_N-1:0] lat_w;

    sc_edge_detect #(.N(SRC_N)) u_edge (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .sig_i   (stat_i),
        .chg_o   (chg_w)
    );

    sc_event_latch #(.N(SRC_N)) u_latch (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .chg_i   (chg_w),
        .en_i    (st_q.ctrl.en),
        .blk_i   (st_q.ctrl.blk),
        .clr_i   (rd_en_i),
        .lat_o   (lat_w)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.ctrl.en     = wr_data_i[EN_BIT];
            st_d.ctrl.master = wr_data_i[MASTER_BIT];
            st_d.ctrl.imask  = wr_data_i[IMASK_BIT];
            st_d.ctrl.blk    = wr_data_i[BLK_LSB +: SRC_N];
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) st_q <= '0;
        else          st_q <= st_d;
    end

    always_comb begin
        irq_o = st_q.ctrl.en && !st_q.ctrl.master && !st_q.ctrl.imask && (lat_w != '0);
        rd_data_o                     = '0;
        rd_data_o[EN_BIT]             = st_q.ctrl.en;
        rd_data_o[MASTER_BIT]         = st_q.ctrl.master;
        rd_data_o[IMASK_BIT]          = st_q.ctrl.imask;
        rd_data_o[BLK_LSB +: SRC_N]   = st_q.ctrl.blk;
        rd_data_o[STS_LSB +: SRC_N]   = lat_w;
        rd_data_o[ANY_BIT]            = |lat_w;
    end

    sc_pin_mux u_pins (
        .irq_mode_i  (st_q.ctrl.en),
        .irq_i       (irq_o),
        .led_tx_n_i  (led_tx_n_i),
        .led_rx_n_i  (led_rx_n_i),
        .act_n_i     (act_n_i),
        .pin_tx_n_o  (pin_tx_n_o),
        .pin_tx_oe_o (pin_tx_oe_o),
        .pin_rx_n_o  (pin_rx_n_o)
    );
endmodule

// File: rtl/phyirq_chk.sv
module phyirq_chk
    import phyirq_pkg::*;
(
    input logic             clk_i,
    input logic             rst_n_i,
    input ctrl_t            ctrl,
    input logic [SRC_N-1:0] chg,
    input logic [SRC_N-1:0] lat,
    input logic             rd_en_i,
    input logic             irq_o,
    input logic             pin_tx_n_o,
    input logic             pin_tx_oe_o
);
    // R2
    event_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ctrl.en && ((chg & ~ctrl.blk) != '0)) |=>
        ((lat & $past(chg & ~ctrl.blk)) == $past(chg & ~ctrl.blk)));

    // R4
    no_set_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !ctrl.en |=> ((lat & ~$past(lat)) == '0));

    // R5
    blocked_src_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ctrl.blk != '0) |=> ((lat & ~$past(lat) & $past(ctrl.blk)) == '0));

    // R6
    read_quiets_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rd_en_i && (chg == '0)) |=> !irq_o);

    // R7
    master_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ctrl.master |-> !irq_o);

    // R8
    read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rd_en_i && (chg == '0)) |=> (lat == '0));

    // R10
    pin_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ctrl.en |-> (!pin_tx_n_o && (pin_tx_oe_o == irq_o)));
endmodule

bind phyirq_ctrl phyirq_chk u_chk (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .ctrl        (st_q.ctrl),
    .chg         (chg_w),
    .lat         (lat_w),
    .rd_en_i     (rd_en_i),
    .irq_o       (irq_o),
    .pin_tx_n_o  (pin_tx_n_o),
    .pin_tx_oe_o (pin_tx_oe_o)
);

// File: tb/phyirq_ctrl_tb.sv
module phyirq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  stat = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        irq;
    logic        led_tx_n = 1'b1, led_rx_n = 1'b1, act_n = 1'b1;
    logic        pin_tx_n, pin_tx_oe, pin_rx_n;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    // model state
    logic       m_en = 0, m_master = 0, m_imask = 0;
    logic [2:0] m_blk = '0, m_lat = '0, m_prev = '0;

    always #2 clk = ~clk;

    phyirq_ctrl dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .stat_i(stat),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
        .rd_data_o(rd_data), .irq_o(irq),
        .led_tx_n_i(led_tx_n), .led_rx_n_i(led_rx_n), .act_n_i(act_n),
        .pin_tx_n_o(pin_tx_n), .pin_tx_oe_o(pin_tx_oe), .pin_rx_n_o(pin_rx_n)
    );

    function automatic logic [15:0] exp_reg();
        logic [15:0] r = '0;
        r[15] = m_en; r[12] = m_master; r[11] = m_imask;
        r[6:4] = m_blk; r[3:1] = m_lat; r[0] = |m_lat;
        return r;
    endfunction

    function automatic logic exp_irq();
        return m_en && !m_master && !m_imask && (m_lat != '0);
    endfunction

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "rd_data", rd_data, exp_reg());
        check(tag, "irq", {15'd0, irq}, {15'd0, exp_irq()});
        check(tag, "pin_tx_n", {15'd0, pin_tx_n}, {15'd0, m_en ? 1'b0 : led_tx_n});
        check(tag, "pin_tx_oe", {15'd0, pin_tx_oe}, {15'd0, m_en ? exp_irq() : 1'b1});
        check(tag, "pin_rx_n", {15'd0, pin_rx_n}, {15'd0, m_en ? act_n : led_rx_n});
    endtask

    // drive at negedge, model the coming edge, then check at the next negedge
    task automatic cycle(input logic wr, input logic [15:0] wd, input logic rd, input logic [2:0] st, input string tag);
        logic [2:0] chg;
        wr_en = wr; wr_data = wd; rd_en = rd; stat = st;
        led_tx_n = 1'($urandom); led_rx_n = 1'($urandom); act_n = 1'($urandom);
        chg = st ^ m_prev;
        m_lat = (rd ? 3'b000 : m_lat) | (chg & ~m_blk & {3{m_en}});
        m_prev = st;
        if (wr) begin
            m_en = wd[15]; m_master = wd[12]; m_imask = wd[11]; m_blk = wd[6:4];
        end
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                tests++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("  [TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [2:0] s;
        void'($urandom(32'h5eed_1a2b));
        stat = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state (LED mode)
        check_all("R1");
        cycle(1, 16'h8000, 0, 3'b000, "R9");   // enable only
        cycle(0, 16'h0000, 0, 3'b001, "R2");   // link rises
        cycle(0, 16'h0000, 1, 3'b001, "R8");   // read clears
        cycle(0, 16'h0000, 0, 3'b000, "R2");   // link falls
        cycle(0, 16'h0000, 1, 3'b010, "R8");   // read with speed change at same edge
        cycle(0, 16'h0000, 1, 3'b010, "R3");   // clean read
        cycle(1, 16'h8800, 0, 3'b010, "R6");   // interrupt mask on
        cycle(0, 16'h0000, 0, 3'b110, "R6");   // duplex latches, no request
        cycle(1, 16'h9000, 0, 3'b110, "R7");   // master mask, imask off
        cycle(0, 16'h0000, 0, 3'b111, "R7");   // link adds status, still quiet
        cycle(1, 16'h8010, 1, 3'b111, "R5");   // clear, block link
        cycle(0, 16'h0000, 0, 3'b110, "R5");   // link change blocked
        cycle(0, 16'h0000, 0, 3'b100, "R5");   // speed change latches
        cycle(1, 16'h0000, 1, 3'b100, "R4");   // disable and clear
        cycle(0, 16'h0000, 0, 3'b011, "R4");   // changes ignored
        cycle(1, 16'hFFFF, 0, 3'b011, "R9");   // read-only bits untouched
        cycle(1, 16'h0000, 1, 3'b011, "R10");  // back to LED mode
        cycle(1, 16'h8000, 0, 3'b010, "R10");  // interrupt mode, no pending
        cycle(0, 16'h0000, 0, 3'b000, "R10");  // pending: pin enabled low
        // random phase
        s = 3'b000;
        for (int i = 0; i < 3000; i++) begin
            logic        w  = ($urandom % 10) == 0;
            logic        r  = ($urandom % 5) == 0;
            logic [15:0] wd = 16'($urandom);
            if (($urandom % 4) == 0) wd[15] = 1'b1;
            if (($urandom % 3) == 0) s = s ^ 3'($urandom);
            cycle(w, wd, r, s, "R2");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule